// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that gives an external controller read and write access to a bank of byte-wide configuration and status registers. A transaction is framed by an active-low select. The first byte is an instruction: bit 7 chooses read (1) or write (0), bits 6:5 give the number of data bytes minus one, and bits 4:0 give the start address. One to four data bytes follow. Every byte is sent most significant bit first. The address steps by one after each data byte.

The serial pins are sampled by the system clock through two-stage synchronizers. Input bits are taken on rising serial-clock edges and read bits are launched on falling edges. In three-wire mode the data pin turns into an output for the data phase of a read. The separate output pin then carries one of eight internal status signals, chosen by a register field. Setting a mode bit selects four-wire operation: read data leaves on the separate output pin and the shared data pin is never driven. Hardware event inputs set three sticky error flags, and software clears each flag by writing a zero to it.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, address 0x02 reads 0xC0, address 0x06 reads 0x0C, address 0x00 reads 0x0B (with both lock inputs low), and every other address reads 0x00.
- R2: The instruction byte holds read=1/write=0 in bit 7, the byte count minus one in bits 6:5 and the address in bits 4:0. Data bytes travel MSB first in both directions.
- R3: In a multi-byte transfer the address increments after each byte and wraps from 31 to 0.
- R4: Data bytes clocked in beyond the count given in the instruction are ignored.
- R5: Address 0x00 is read-only. It reads {pll_locked, dll_locked, 0, device id 3'b010, revision 2'b11}.
- R6: Address 0x04 holds sticky flags in bit 6 (self-test), bit 5 (FIFO) and bit 4 (pattern). An event input pulse sets its flag. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. All other bits of the address read 0.
- R7: When an event arrives in the same cycle as a write that clears its flag, the flag ends up set.
- R8: In three-wire mode, sdio_oe is high only during the data phase of a read, and it drops once sen_n is high again.
- R9: When bit 6 of address 0x05 is 1 (four-wire mode), read data appears on sdo and sdio_oe stays low.
- R10: In three-wire mode, sdo shows the signal chosen by bits 7:5 of address 0x0E: 0 gives zero, 1 gives pll_locked, 2 gives dll_locked, 3 gives the self-test flag, 4 gives the FIFO flag, 5 gives the pattern flag, 6 gives the OR of all flags, and 7 gives pll_locked AND dll_locked.
- R11: A byte left incomplete when sen_n rises is not written. Bytes completed before that point are written.
- R12: Addresses 0x10 to 0x1F read 0 and ignore writes.
- R13: Read data changes only after a falling serial-clock edge and stays stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| sen_n | input | 1 | Active-low transaction select |
| sdio_in | input | 1 | Serial data input (shared pin, input side) |
| sdio_out | output | 1 | Serial read data (shared pin, output side) |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Separate output: read data in four-wire mode, status mux in three-wire mode |
| pll_locked | input | 1 | Lock status shown in address 0x00 bit 7 |
| dll_locked | input | 1 | Lock status shown in address 0x00 bit 6 |
| ev_selftest | input | 1 | Sets the self-test flag |
| ev_fifo | input | 1 | Sets the FIFO flag |
| ev_pattern | input | 1 | Sets the pattern flag |
| cfg_q | output | NREGS*8 | Current contents of all implemented registers, byte i at bits 8i+7:8i |

## Verification
A wrong bit counter or a wrong address pointer shows up in the very next read-back, as a byte shifted by one bit or a byte taken from the neighbouring address. Sweeping every address with a distinct value exposes any aliasing. A bad sticky-flag update shows in the next read of address 0x04, and also at once on sdo when the status mux points at that flag. A wrong direction state is visible on sdio_oe within the same serial bit in which it goes wrong.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NREGS = 16,
  parameter logic [2:0] DEV_ID = 3'b010,
  parameter logic [1:0] REV = 2'b11,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sen_n,
  input  logic               sdio_in,
  output logic               sdio_out,
  output logic               sdio_oe,
  output logic               sdo,
  input  logic               pll_locked,
  input  logic               dll_locked,
  input  logic               ev_selftest,
  input  logic               ev_fifo,
  input  logic               ev_pattern,
  output logic [NREGS*8-1:0] cfg_q
);
  localparam int AW = 5;
  localparam int STAT_A = 0;
  localparam int ERR_A = 4;
  localparam int MODE_A = 5;
  localparam int MODE_BIT = 6;
  localparam int MUX_A = 14;

  function automatic logic [7:0] dflt(input int i);
    case (i)
      2: return 8'hC0;
      6: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  logic [SYNC_STAGES-1:0] sclk_sr, sen_sr, sdi_sr;
  logic sclk_q, sclk_d, sen_q, sdi_q, rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sr <= '0;
      sen_sr  <= '1;
      sdi_sr  <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
      sen_sr  <= {sen_sr[SYNC_STAGES-2:0], sen_n};
      sdi_sr  <= {sdi_sr[SYNC_STAGES-2:0], sdio_in};
      sclk_d  <= sclk_q;
    end

  assign sclk_q = sclk_sr[SYNC_STAGES-1];
  assign sen_q  = sen_sr[SYNC_STAGES-1];
  assign sdi_q  = sdi_sr[SYNC_STAGES-1];
  assign rise   = sclk_q & ~sclk_d & ~sen_q;
  assign fall   = ~sclk_q & sclk_d & ~sen_q;

  logic [7:0] shin, shout, nb, rd_byte;
  logic [2:0] bitc;
  logic [1:0] left;
  logic [AW-1:0] ptr;
  logic in_cmd, rd_ph, wr_ph, done, dout;
  logic [7:0] regs [NREGS];
  logic [2:0] err, ev;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic mode4;
  logic [2:0] msel;
  logic mux_o;

  assign nb = {shin[6:0], sdi_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shin <= '0; bitc <= '0; left <= '0; ptr <= '0;
      in_cmd <= 1'b1; rd_ph <= 1'b0; wr_ph <= 1'b0; done <= 1'b0;
    end else if (sen_q) begin
      bitc <= '0; in_cmd <= 1'b1; rd_ph <= 1'b0; wr_ph <= 1'b0; done <= 1'b0;
    end else if (rise) begin
      shin <= nb;
      bitc <= bitc + 3'd1;
      if (bitc == 3'd7) begin
        if (in_cmd) begin
          in_cmd <= 1'b0;
          rd_ph  <= nb[7];
          wr_ph  <= ~nb[7];
          left   <= nb[6:5];
          ptr    <= nb[4:0];
        end else if (!done) begin
          ptr <= ptr + 1'b1;
          if (left == 2'd0) done <= 1'b1;
          else left <= left - 2'd1;
        end
      end
    end

  assign wr_en   = rise && bitc == 3'd7 && !in_cmd && wr_ph && !done;
  assign wr_addr = ptr;
  assign ev      = {ev_selftest, ev_fifo, ev_pattern};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= dflt(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREGS; i++)
        if (i != STAT_A && i != ERR_A && wr_addr == AW'(i)) regs[i] <= nb;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= '0;
    else if (wr_en && wr_addr == AW'(ERR_A)) err <= (err & nb[6:4]) | ev;
    else err <= err | ev;

  always_comb begin
    for (int i = 0; i < NREGS; i++) begin
      if (i == STAT_A) cfg_q[i*8 +: 8] = {pll_locked, dll_locked, 1'b0, DEV_ID, REV};
      else if (i == ERR_A) cfg_q[i*8 +: 8] = {1'b0, err, 4'b0};
      else cfg_q[i*8 +: 8] = regs[i];
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREGS; i++)
      if (ptr == AW'(i)) rd_byte = cfg_q[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shout <= '0; dout <= 1'b0;
    end else if (sen_q) begin
      dout <= 1'b0;
    end else if (fall && rd_ph) begin
      if (done) dout <= 1'b0;
      else if (bitc == 3'd0) begin
        dout  <= rd_byte[7];
        shout <= {rd_byte[6:0], 1'b0};
      end else begin
        dout  <= shout[7];
        shout <= {shout[6:0], 1'b0};
      end
    end

  assign mode4 = regs[MODE_A][MODE_BIT];
  assign msel  = regs[MUX_A][7:5];

  always_comb
    case (msel)
      3'd1: mux_o = pll_locked;
      3'd2: mux_o = dll_locked;
      3'd3: mux_o = err[2];
      3'd4: mux_o = err[1];
      3'd5: mux_o = err[0];
      3'd6: mux_o = |err;
      3'd7: mux_o = pll_locked & dll_locked;
      default: mux_o = 1'b0;
    endcase

  assign sdio_out = dout;
  assign sdio_oe  = rd_ph & ~sen_q & ~mode4;
  assign sdo      = mode4 ? (rd_ph & ~sen_q & dout) : mux_o;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int NREGS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sen_q,
  input logic               sclk_q,
  input logic               sclk_d,
  input logic               dout,
  input logic               sdio_oe,
  input logic               mode4,
  input logic               wr_en,
  input logic [4:0]         wr_addr,
  input logic [2:0]         err,
  input logic [2:0]         ev,
  input logic [NREGS*8-1:0] cfg_q
);
  AST_DOUT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && sclk_d && !sen_q && !$past(sen_q)) |-> $stable(dout)); // R13

  AST_OE_NOT_4W: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !mode4); // R9

  AST_OE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !sen_q); // R8

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sen_q |-> !wr_en); // R11

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == 3'b000 && !(wr_en && wr_addr == 5'd4)) |=> $stable(err)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 3'b000) |=> ((err & $past(ev)) == $past(ev))); // R7

  AST_HIGH_SPACE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 5'(NREGS) && ev == 3'b000) |=> $stable(cfg_q[NREGS*8-1:8])); // R12
endmodule

bind serial_cfg_port serial_cfg_port_chk #(.NREGS(NREGS)) u_chk (.*);

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  localparam int NREGS = 16;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdio_in = 1'b0;
  logic pll_locked = 1'b0, dll_locked = 1'b0;
  logic ev_selftest = 1'b0, ev_fifo = 1'b0, ev_pattern = 1'b0;
  logic sdio_out, sdio_oe, sdo;
  logic [NREGS*8-1:0] cfg_q;

  int total = 0, bad = 0;
  bit four_w = 1'b0;
  logic [7:0] m [NREGS];
  logic [2:0] err_m = 3'b000;

  always #2 clk = ~clk;

  serial_cfg_port #(.NREGS(NREGS)) dut (.*);

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 0) return {pll_locked, dll_locked, 6'b001011};
    if (a == 4) return {1'b0, err_m, 4'b0};
    if (a < NREGS) return m[a];
    return 8'h00;
  endfunction

  task automatic xfer(input bit rd, input int lenf, input int a, input logic [31:0] wd,
                      input int dbits, output logic [31:0] rdo, output bit oe_ok, output bit stab_ok);
    logic [7:0] ins;
    logic sb;
    ins = {rd, 2'(lenf), 5'(a)};
    rdo = '0; oe_ok = 1'b1; stab_ok = 1'b1;
    sen_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 8 + dbits; i++) begin
      sdio_in = (i < 8) ? ins[7-i] : wd[31-(i-8)];
      wait_clk(HP);
      sb = four_w ? sdo : sdio_out;
      if (i >= 8) begin
        rdo = {rdo[30:0], sb};
        if (sdio_oe != (rd && !four_w)) oe_ok = 1'b0;
      end else if (sdio_oe) oe_ok = 1'b0;
      sclk = 1'b1;
      wait_clk(HP);
      if (i >= 8 && (four_w ? sdo : sdio_out) != sb) stab_ok = 1'b0;
      sclk = 1'b0;
    end
    wait_clk(HP);
    sen_n = 1'b1;
    wait_clk(2 * HP);
  endtask

  task automatic rd1(input int a, output logic [7:0] v);
    logic [31:0] r; bit o, s;
    xfer(1'b1, 0, a, '0, 8, r, o, s);
    v = r[7:0];
  endtask

  task automatic wr1(input int a, input logic [7:0] v);
    logic [31:0] r; bit o, s;
    xfer(1'b0, 0, a, {v, 24'h0}, 8, r, o, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [31:0] r;
    bit o, s;
    for (int i = 0; i < NREGS; i++) m[i] = (i == 2) ? 8'hC0 : (i == 6) ? 8'h0C : 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset values at every address
    for (int a = 0; a < 32; a++) begin
      rd1(a, v);
      check(v == exp_rd(a), "R1", v, exp_rd(a));
    end
    check(sdo == 1'b0 && sdio_oe == 1'b0, "R1", {sdo, sdio_oe}, 0);

    // R2 R12 write sweep then single reads
    for (int a = 1; a < 32; a++) begin
      logic [7:0] p;
      p = 8'((a * 29 + 3) & 8'hFF);
      if (a == 5) p = p & 8'hBF;
      wr1(a, p);
      if (a < NREGS && a != 4) m[a] = p;
    end
    for (int a = 0; a < 32; a++) begin
      rd1(a, v);
      check(v == exp_rd(a), "R2 R12", v, exp_rd(a));
    end

    // R3 burst reads incl wrap, R8 oe during read and R13 stability
    for (int a = 0; a < 32; a += 3) begin
      logic [31:0] e;
      xfer(1'b1, 3, a, '0, 32, r, o, s);
      e = {exp_rd((a) % 32), exp_rd((a + 1) % 32), exp_rd((a + 2) % 32), exp_rd((a + 3) % 32)};
      check(r == e, "R3", r, e);
      check(o, "R8", o, 1);
      check(s, "R13", s, 1);
    end
    check(sdio_oe == 1'b0, "R8", sdio_oe, 0);

    // R3 burst write with address increment
    xfer(1'b0, 3, 8, 32'hA1B2C3D4, 32, r, o, s);
    m[8] = 8'hA1; m[9] = 8'hB2; m[10] = 8'hC3; m[11] = 8'hD4;
    check(o, "R8", o, 1);
    for (int a = 8; a < 12; a++) begin
      rd1(a, v);
      check(v == m[a], "R3", v, m[a]);
    end

    // R4 surplus bytes ignored
    xfer(1'b0, 0, 12, 32'h5A6B7C8D, 24, r, o, s);
    m[12] = 8'h5A;
    for (int a = 12; a < 15; a++) begin
      rd1(a, v);
      check(v == m[a], "R4", v, m[a]);
    end

    // R11 abort mid byte
    xfer(1'b0, 0, 9, 32'hFF000000, 5, r, o, s);
    rd1(9, v);
    check(v == m[9], "R11", v, m[9]);
    xfer(1'b0, 1, 10, 32'h3CFF0000, 12, r, o, s);
    m[10] = 8'h3C;
    rd1(10, v); check(v == m[10], "R11", v, m[10]);
    rd1(11, v); check(v == m[11], "R11", v, m[11]);

    // R5 status read-only and lock bits
    pll_locked = 1'b1; wait_clk(2);
    rd1(0, v); check(v == 8'h8B, "R5", v, 8'h8B);
    dll_locked = 1'b1; wait_clk(2);
    wr1(0, 8'h00);
    rd1(0, v); check(v == 8'hCB, "R5", v, 8'hCB);
    pll_locked = 1'b0;

    // R6 sticky flags
    ev_fifo = 1'b1; wait_clk(1); ev_fifo = 1'b0; err_m[1] = 1'b1; wait_clk(2);
    rd1(4, v); check(v == 8'h20, "R6", v, 8'h20);
    wr1(4, 8'hFF);
    rd1(4, v); check(v == 8'h20, "R6", v, 8'h20);
    wr1(4, 8'h00); err_m = 3'b000;
    rd1(4, v); check(v == 8'h00, "R6", v, 8'h00);
    ev_selftest = 1'b1; ev_fifo = 1'b1; ev_pattern = 1'b1; wait_clk(1);
    ev_selftest = 1'b0; ev_fifo = 1'b0; ev_pattern = 1'b0; wait_clk(2);
    wr1(4, 8'h40); err_m = 3'b100;
    rd1(4, v); check(v == 8'h40, "R6", v, 8'h40);

    // R7 event during clearing write
    ev_pattern = 1'b1;
    wr1(4, 8'h00);
    ev_pattern = 1'b0; err_m = 3'b001;
    rd1(4, v); check(v == 8'h10, "R7", v, 8'h10);

    // R10 status mux sweep: pll=1 dll=0, only FIFO flag set
    wr1(4, 8'h00);
    ev_fifo = 1'b1; wait_clk(1); ev_fifo = 1'b0; err_m = 3'b010;
    pll_locked = 1'b1; dll_locked = 1'b0;
    for (int sel = 0; sel < 8; sel++) begin
      logic e;
      wr1(14, 8'(sel << 5)); m[14] = 8'(sel << 5);
      case (sel)
        1: e = pll_locked;
        2: e = dll_locked;
        3: e = err_m[2];
        4: e = err_m[1];
        5: e = err_m[0];
        6: e = |err_m;
        7: e = pll_locked & dll_locked;
        default: e = 1'b0;
      endcase
      check(sdo == e, "R10", sdo, e);
    end

    // R9 four-wire mode
    wr1(5, 8'h40); m[5] = 8'h40; four_w = 1'b1;
    xfer(1'b1, 1, 2, '0, 16, r, o, s);
    check(r[15:0] == {m[2], m[3]}, "R9", r[15:0], {m[2], m[3]});
    check(o, "R9", o, 1);
    check(sdo == 1'b0, "R9", sdo, 0);
    wr1(5, 8'h00); m[5] = 8'h00; four_w = 1'b0;
    rd1(5, v); check(v == 8'h00, "R9", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule